// File: doc/BRIEF.md
# Palette Lookup and Direct-Color Unpacker

This block is the digital front end of a display color converter. Every clock it takes one pixel word and turns it into a 24-bit RGB value, with red in the top byte. How it reads the word depends on a pixel-format select.

In the indexed format, the low byte of the word addresses three palette tables, one each for red, green and blue. Each table holds 256 entries of 6 bits. Each entry read out is widened to 8 bits. The three direct-color formats bypass the tables completely: a 15-bit packing, a 16-bit packing and a 24-bit pass-through. A doubled indexed format takes two indices per clock from one 16-bit word and returns two RGB results in the same cycle.

A host port fills the tables through a write pointer that steps by one after each write. The same port reads back any entry, one cycle later. Every result is registered with one cycle of latency, and a valid flag travels with it. The result registers hold their last value while no pixel is presented.

Top module: `pal_color_conv`

## Requirements
- R1: While reset is asserted, `out_valid_o`, `out_pair_o`, both RGB outputs and `hr_data_o` read zero.
- R2: A host write (`hw_wr_i`) stores `hw_data_i` into the table picked by `hw_comp_i` (0 red, 1 green, 2 blue). Code 3 stores nothing. The write lands at the write pointer, and the pointer then steps by one, wrapping from 255 to 0; it steps for code 3 as well. `hw_addr_ld_i` loads the pointer from `hw_addr_i`. A write in the same cycle uses the loaded address.
- R3: When `pix_mode_i` is 0 (indexed), bits 7:0 of the pixel word index all three tables. A 6-bit entry e is output as the 8-bit value {e, e[5:4]}. The result is {R, G, B} in bits 23:16, 15:8 and 7:0.
- R4: When `pix_mode_i` is 1 (15-bit), red is bits 14:10, green 9:5 and blue 4:0. Bits 15 and above are ignored. A 5-bit field f is output as {f, f[4:2]}.
- R5: When `pix_mode_i` is 2 (16-bit), red is bits 15:11, widened as in R4. Green is bits 10:5, widened as in R3. Blue is bits 4:0, widened as in R4.
- R6: When `pix_mode_i` is 3 (24-bit), the pixel word passes through unchanged as the RGB result.
- R7: When `dbl_mode_i` is set in mode 0, bits 7:0 produce `out_rgb0_o` and bits 15:8 produce `out_rgb1_o`, both as in R3, and `out_pair_o` is 1. In every other case `out_rgb1_o` is zero and `out_pair_o` is 0; `dbl_mode_i` is ignored in modes 1 to 3.
- R8: Results appear one clock after the pixel is presented. `out_valid_o` equals `pix_valid_i` delayed by one clock. When `pix_valid_i` is low, the RGB outputs and `out_pair_o` keep their previous values.
- R9: When a host write and a lookup hit the same entry in the same cycle, the lookup returns the old contents. The new value is seen from the next cycle on.
- R10: One clock after the request, `hr_data_o` shows the entry at `hr_addr_i` in the table picked by `hr_comp_i`, using the same codes as R2. Code 3 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel word present this cycle |
| pix_data_i | input | 24 | Pixel word |
| pix_mode_i | input | 2 | Format: 0 indexed, 1 15-bit, 2 16-bit, 3 24-bit |
| dbl_mode_i | input | 1 | Two indices per word (mode 0 only) |
| hw_addr_ld_i | input | 1 | Load the write pointer |
| hw_addr_i | input | 8 | Write pointer load value |
| hw_wr_i | input | 1 | Host table write |
| hw_comp_i | input | 2 | Write target table: 0 red, 1 green, 2 blue |
| hw_data_i | input | 6 | Entry value to write |
| hr_addr_i | input | 8 | Host read entry address |
| hr_comp_i | input | 2 | Host read table select |
| hr_data_o | output | 6 | Host read data, one cycle later |
| out_valid_o | output | 1 | Result valid |
| out_pair_o | output | 1 | Second result present |
| out_rgb0_o | output | 24 | First (or only) RGB result |
| out_rgb1_o | output | 24 | Second RGB result in doubled mode |

## Verification
The hardest case to reach is a host write that lands on the very entry being looked up in the same cycle, and it must be caught through either index slot of the doubled mode. To set this up, the bench loads the write pointer with a chosen address and, in the same cycle, presents a pixel word whose low or high byte equals that address. It then repeats the lookup without a write to show the new value. A long mixed phase adds random host writes, random host reads and random pixel traffic in all formats. In that phase these collisions, pointer wraps and writes with code 3 also happen without being arranged.

// File: rtl/pal_pkg.sv
package pal_pkg;
   typedef enum logic [1:0] {
      PM_IDX8 = 2'd0,
      PM_HC15 = 2'd1,
      PM_HC16 = 2'd2,
      PM_TC24 = 2'd3
   } pix_mode_e;

   localparam int N_COMP = 3;
   localparam logic [1:0] SEL_RED = 2'd0;
   localparam logic [1:0] SEL_GRN = 2'd1;
   localparam logic [1:0] SEL_BLU = 2'd2;
endpackage

// File: rtl/pal_widen.sv
// Widens an unsigned intensity by appending copies of its top bits.
module pal_widen #(
   parameter int IN_W  = 6,
   parameter int OUT_W = 8
) (
   input  logic [IN_W-1:0]  narrow_i,
   output logic [OUT_W-1:0] wide_o
);
   generate
      if (OUT_W == IN_W) begin : g_same
         assign wide_o = narrow_i;
      end else if (OUT_W > IN_W && OUT_W - IN_W <= IN_W) begin : g_rep
         assign wide_o = {narrow_i, narrow_i[IN_W-1 -: OUT_W-IN_W]};
      end else begin : g_bad
         $error("pal_widen: OUT_W must lie in [IN_W, 2*IN_W]");
      end
   endgenerate
endmodule

// File: rtl/pal_table.sv
// One color-component table: one write port, LK_PORTS lookup ports and a host read port.
module pal_table #(
   parameter int IDX_W    = 8,
   parameter int ENT_W    = 6,
   parameter int LK_PORTS = 2
) (
   input  logic                      clk,
   input  logic                      wr_en_i,
   input  logic [IDX_W-1:0]          wr_addr_i,
   input  logic [ENT_W-1:0]          wr_data_i,
   input  logic [LK_PORTS*IDX_W-1:0] lk_addr_i,
   output logic [LK_PORTS*ENT_W-1:0] lk_data_o,
   input  logic [IDX_W-1:0]          hr_addr_i,
   output logic [ENT_W-1:0]          hr_data_o
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_depth
         $error("pal_table: IDX_W out of range");
      end
      if (LK_PORTS < 1) begin : g_bad_ports
         $error("pal_table: need at least one lookup port");
      end
   endgenerate

   logic [ENT_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
   end

   generate
      for (genvar p = 0; p < LK_PORTS; p++) begin : g_lk
         assign lk_data_o[p*ENT_W +: ENT_W] = mem[lk_addr_i[p*IDX_W +: IDX_W]];
      end
   endgenerate

   assign hr_data_o = mem[hr_addr_i];
endmodule

// File: rtl/pal_direct.sv
// Direct-color unpacker for the 15-bit, 16-bit and 24-bit formats.
module pal_direct
   import pal_pkg::*;
#(
   parameter int CH_W = 8
) (
   input  logic [3*CH_W-1:0] pix_i,
   input  pix_mode_e         mode_i,
   output logic [3*CH_W-1:0] rgb_o
);
   localparam int N_F5 = 5;

   generate
      if (CH_W < 6 || CH_W > 10) begin : g_bad_ch
         $error("pal_direct: CH_W must lie in [6, 10]");
      end
   endgenerate

   // Slots 0..2: 15-bit red/green/blue; slots 3,4: 16-bit red/blue.
   logic [4:0]      f5 [N_F5];
   logic [CH_W-1:0] w5 [N_F5];
   logic [5:0]      g16;
   logic [CH_W-1:0] g16_w;

   assign f5[0] = pix_i[14:10];
   assign f5[1] = pix_i[9:5];
   assign f5[2] = pix_i[4:0];
   assign f5[3] = pix_i[15:11];
   assign f5[4] = pix_i[4:0];
   assign g16   = pix_i[10:5];

   generate
      for (genvar k = 0; k < N_F5; k++) begin : g_w5
         pal_widen #(.IN_W(5), .OUT_W(CH_W)) u_w5 (
            .narrow_i (f5[k]),
            .wide_o   (w5[k])
         );
      end
   endgenerate

   pal_widen #(.IN_W(6), .OUT_W(CH_W)) u_w6 (
      .narrow_i (g16),
      .wide_o   (g16_w)
   );

   always_comb begin
      case (mode_i)
         PM_HC15: rgb_o = {w5[0], w5[1], w5[2]};
         PM_HC16: rgb_o = {w5[3], g16_w, w5[4]};
         PM_TC24: rgb_o = pix_i;
         default: rgb_o = '0;
      endcase
   end
endmodule

// File: rtl/pal_color_conv.sv
// Palette lookup with direct-color bypass and two-index doubled mode.
module pal_color_conv
   import pal_pkg::*;
#(
   parameter int IDX_W  = 8,
   parameter int ENT_W  = 6,
   parameter int CH_W   = 8,
   parameter bit DBL_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pix_valid_i,
   input  logic [3*CH_W-1:0]   pix_data_i,
   input  logic [1:0]          pix_mode_i,
   input  logic                dbl_mode_i,
   input  logic                hw_addr_ld_i,
   input  logic [IDX_W-1:0]    hw_addr_i,
   input  logic                hw_wr_i,
   input  logic [1:0]          hw_comp_i,
   input  logic [ENT_W-1:0]    hw_data_i,
   input  logic [IDX_W-1:0]    hr_addr_i,
   input  logic [1:0]          hr_comp_i,
   output logic [ENT_W-1:0]    hr_data_o,
   output logic                out_valid_o,
   output logic                out_pair_o,
   output logic [3*CH_W-1:0]   out_rgb0_o,
   output logic [3*CH_W-1:0]   out_rgb1_o
);
   localparam int PIX_W    = 3 * CH_W;
   localparam int LK_PORTS = DBL_EN ? 2 : 1;

   generate
      if (ENT_W > CH_W || 2 * ENT_W < CH_W) begin : g_bad_ent
         $error("pal_color_conv: ENT_W must lie in [CH_W/2, CH_W]");
      end
      if (LK_PORTS * IDX_W > PIX_W) begin : g_bad_idx
         $error("pal_color_conv: pixel word too narrow for the indices");
      end
   endgenerate

   pix_mode_e mode;
   assign mode = pix_mode_e'(pix_mode_i);

   // Host write pointer
   logic [IDX_W-1:0] wr_ptr;
   logic [IDX_W-1:0] wr_addr;

   assign wr_addr = hw_addr_ld_i ? hw_addr_i : wr_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            wr_ptr <= '0;
      else if (hw_wr_i)      wr_ptr <= wr_addr + 1'b1;
      else if (hw_addr_ld_i) wr_ptr <= hw_addr_i;
   end

   // Component tables and widening
   logic [LK_PORTS*IDX_W-1:0] lk_addr;
   logic [ENT_W-1:0]          hr_raw  [N_COMP];
   logic [CH_W-1:0]           lk_wide [N_COMP][LK_PORTS];
   logic [PIX_W-1:0]          rgb_idx [LK_PORTS];

   generate
      for (genvar p = 0; p < LK_PORTS; p++) begin : g_addr
         assign lk_addr[p*IDX_W +: IDX_W] = pix_data_i[p*IDX_W +: IDX_W];
      end

      for (genvar c = 0; c < N_COMP; c++) begin : g_comp
         logic [LK_PORTS*ENT_W-1:0] lk_ent;
         logic                      wr_en;

         assign wr_en = hw_wr_i && (hw_comp_i == 2'(c));

         pal_table #(
            .IDX_W    (IDX_W),
            .ENT_W    (ENT_W),
            .LK_PORTS (LK_PORTS)
         ) u_tab (
            .clk       (clk),
            .wr_en_i   (wr_en),
            .wr_addr_i (wr_addr),
            .wr_data_i (hw_data_i),
            .lk_addr_i (lk_addr),
            .lk_data_o (lk_ent),
            .hr_addr_i (hr_addr_i),
            .hr_data_o (hr_raw[c])
         );

         for (genvar p = 0; p < LK_PORTS; p++) begin : g_wide
            pal_widen #(.IN_W(ENT_W), .OUT_W(CH_W)) u_wid (
               .narrow_i (lk_ent[p*ENT_W +: ENT_W]),
               .wide_o   (lk_wide[c][p])
            );
         end
      end

      for (genvar p = 0; p < LK_PORTS; p++) begin : g_pack
         assign rgb_idx[p] = {lk_wide[0][p], lk_wide[1][p], lk_wide[2][p]};
      end
   endgenerate

   // Direct-color path
   logic [PIX_W-1:0] dir_rgb;

   pal_direct #(.CH_W(CH_W)) u_dir (
      .pix_i  (pix_data_i),
      .mode_i (mode),
      .rgb_o  (dir_rgb)
   );

   // Result selection
   logic             pair_act;
   logic [PIX_W-1:0] nxt_rgb0;
   logic [PIX_W-1:0] nxt_rgb1;
   logic [ENT_W-1:0] hr_sel;

   always_comb begin
      pair_act = DBL_EN && dbl_mode_i && (mode == PM_IDX8);
      nxt_rgb0 = (mode == PM_IDX8) ? rgb_idx[0] : dir_rgb;
      nxt_rgb1 = pair_act ? rgb_idx[LK_PORTS-1] : '0;
      case (hr_comp_i)
         SEL_RED: hr_sel = hr_raw[0];
         SEL_GRN: hr_sel = hr_raw[1];
         SEL_BLU: hr_sel = hr_raw[2];
         default: hr_sel = '0;
      endcase
   end

   // Output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_pair_o  <= 1'b0;
         out_rgb0_o  <= '0;
         out_rgb1_o  <= '0;
         hr_data_o   <= '0;
      end else begin
         out_valid_o <= pix_valid_i;
         hr_data_o   <= hr_sel;
         if (pix_valid_i) begin
            out_pair_o <= pair_act;
            out_rgb0_o <= nxt_rgb0;
            out_rgb1_o <= nxt_rgb1;
         end
      end
   end
endmodule

// File: rtl/pal_color_conv_chk.sv
// Property checker attached to pal_color_conv.
module pal_color_conv_chk #(
   parameter int CH_W  = 8,
   parameter int ENT_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pix_valid_i,
   input logic [3*CH_W-1:0] pix_data_i,
   input logic [1:0]        pix_mode_i,
   input logic              dbl_mode_i,
   input logic              out_valid_o,
   input logic              out_pair_o,
   input logic [3*CH_W-1:0] out_rgb0_o,
   input logic [3*CH_W-1:0] out_rgb1_o
);
   localparam int EXT = CH_W - ENT_W;

   logic past_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> out_valid_o == $past(pix_valid_i)); // R8

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(pix_valid_i) |-> $stable(out_rgb0_o) && $stable(out_rgb1_o)); // R8

   AST_PAIR_ONLY_INDEXED: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(pix_valid_i) && !($past(dbl_mode_i) && $past(pix_mode_i) == 2'd0)
      |-> !out_pair_o && out_rgb1_o == '0); // R7

   AST_TRUE_COLOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(pix_valid_i) && $past(pix_mode_i) == 2'd3
      |-> out_rgb0_o == $past(pix_data_i)); // R6

   generate
      if (EXT > 0) begin : g_rep
         for (genvar c = 0; c < 3; c++) begin : g_ch
            AST_IDX_LOW_REPLICA: assert property (@(posedge clk) disable iff (!rst_n)
               past_ok && $past(pix_valid_i) && $past(pix_mode_i) == 2'd0
               |-> out_rgb0_o[c*CH_W +: EXT] == out_rgb0_o[c*CH_W + CH_W - EXT +: EXT]); // R3
         end
      end
   endgenerate
endmodule

bind pal_color_conv pal_color_conv_chk #(.CH_W(CH_W), .ENT_W(ENT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pix_valid_i (pix_valid_i),
   .pix_data_i  (pix_data_i),
   .pix_mode_i  (pix_mode_i),
   .dbl_mode_i  (dbl_mode_i),
   .out_valid_o (out_valid_o),
   .out_pair_o  (out_pair_o),
   .out_rgb0_o  (out_rgb0_o),
   .out_rgb1_o  (out_rgb1_o)
);

// File: tb/tb_pal_color_conv.sv
module tb_pal_color_conv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid;
   logic [23:0] pix_data;
   logic [1:0]  pix_mode;
   logic        dbl_mode;
   logic        hw_addr_ld;
   logic [7:0]  hw_addr;
   logic        hw_wr;
   logic [1:0]  hw_comp;
   logic [5:0]  hw_data;
   logic [7:0]  hr_addr;
   logic [1:0]  hr_comp;
   logic [5:0]  hr_data;
   logic        out_valid;
   logic        out_pair;
   logic [23:0] out_rgb0;
   logic [23:0] out_rgb1;

   always #10 clk = ~clk;

   pal_color_conv dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .pix_valid_i  (pix_valid),
      .pix_data_i   (pix_data),
      .pix_mode_i   (pix_mode),
      .dbl_mode_i   (dbl_mode),
      .hw_addr_ld_i (hw_addr_ld),
      .hw_addr_i    (hw_addr),
      .hw_wr_i      (hw_wr),
      .hw_comp_i    (hw_comp),
      .hw_data_i    (hw_data),
      .hr_addr_i    (hr_addr),
      .hr_comp_i    (hr_comp),
      .hr_data_o    (hr_data),
      .out_valid_o  (out_valid),
      .out_pair_o   (out_pair),
      .out_rgb0_o   (out_rgb0),
      .out_rgb1_o   (out_rgb1)
   );

   // Reference model state
   int    tab [3][256];
   int    ptr;
   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   logic        e_valid, e_pair;
   logic [23:0] e_rgb0, e_rgb1;
   logic [5:0]  e_rd;
   string rd_tag = "R10";

   function automatic int w6(int e);
      return ((e * 4) + (e / 16)) % 256;
   endfunction

   function automatic int w5(int f);
      return ((f * 8) + (f / 4)) % 256;
   endfunction

   function automatic int look(int idx);
      return w6(tab[0][idx]) * 65536 + w6(tab[1][idx]) * 256 + w6(tab[2][idx]);
   endfunction

   function automatic int direct(int mode, int px);
      int r, g, b;
      if (mode == 1) begin
         r = (px / 1024) % 32; g = (px / 32) % 32; b = px % 32;
         return w5(r) * 65536 + w5(g) * 256 + w5(b);
      end
      if (mode == 2) begin
         r = (px / 2048) % 32; g = (px / 32) % 64; b = px % 32;
         return w5(r) * 65536 + w6(g) * 256 + w5(b);
      end
      return px % 16777216;
   endfunction

   task automatic chk(string tag, string what, longint act, longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      pix_valid = 0; pix_data = '0; pix_mode = 0; dbl_mode = 0;
      hw_addr_ld = 0; hw_addr = '0; hw_wr = 0; hw_comp = 0; hw_data = '0;
      hr_addr = '0; hr_comp = 0;
   endtask

   // Called at a falling edge with inputs already driven.
   task automatic tick();
      int    i0, i1, wa;
      bit    pair, hit;
      string tg, tg1;
      i0   = int'(pix_data[7:0]);
      i1   = int'(pix_data[15:8]);
      pair = dbl_mode && pix_mode == 2'd0;
      wa   = hw_addr_ld ? int'(hw_addr) : ptr;
      hit  = hw_wr && hw_comp != 2'd3 && pix_valid && pix_mode == 2'd0 &&
             (wa == i0 || (pair && wa == i1));
      if (!pix_valid)          tg = "R8";
      else if (hit)            tg = "R9";
      else if (pair)           tg = "R7";
      else if (pix_mode == 0)  tg = "R3";
      else if (pix_mode == 1)  tg = "R4";
      else if (pix_mode == 2)  tg = "R5";
      else                     tg = "R6";
      tg1 = !pix_valid ? "R8" : (hit ? "R9" : "R7");
      e_valid = pix_valid;
      if (pix_valid) begin
         e_rgb0 = 24'(pix_mode == 2'd0 ? look(i0) : direct(int'(pix_mode), int'(pix_data)));
         e_rgb1 = 24'(pair ? look(i1) : 0);
         e_pair = pair;
      end
      e_rd = (hr_comp != 2'd3) ? 6'(tab[hr_comp][hr_addr]) : 6'd0;
      if (hw_addr_ld) ptr = int'(hw_addr);
      if (hw_wr) begin
         if (hw_comp != 2'd3) tab[hw_comp][wa] = int'(hw_data);
         ptr = (wa + 1) % 256;
      end
      @(posedge clk);
      @(negedge clk);
      chk("R8", "out_valid", out_valid, e_valid);
      chk(tg, "rgb0", out_rgb0, e_rgb0);
      chk(tg1, "rgb1", out_rgb1, e_rgb1);
      chk(tg1, "pair", out_pair, e_pair);
      chk(rd_tag, "hr_data", hr_data, e_rd);
   endtask

   task automatic rand_pix(int mode, bit dbl);
      pix_valid = ($urandom % 4) != 0;
      pix_data  = 24'($urandom);
      pix_mode  = 2'(mode);
      dbl_mode  = dbl;
      hr_addr   = 8'($urandom);
      hr_comp   = 2'($urandom);
   endtask

   initial begin
      idle();
      e_valid = 0; e_pair = 0; e_rgb0 = '0; e_rgb1 = '0; e_rd = '0; ptr = 0;
      repeat (3) @(negedge clk);
      chk("R1", "valid in reset", out_valid, 0);
      chk("R1", "rgb0 in reset", out_rgb0, 0);
      chk("R1", "rgb1 in reset", out_rgb1, 0);
      chk("R1", "pair in reset", out_pair, 0);
      chk("R1", "hr_data in reset", hr_data, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1", "valid after reset", out_valid, 0);

      // R2: fill every table via the auto-incrementing pointer
      for (int c = 0; c < 3; c++) begin
         for (int i = 0; i < 256; i++) begin
            idle();
            hw_addr_ld = (i == 0);
            hw_addr    = 8'd0;
            hw_wr      = 1;
            hw_comp    = 2'(c);
            hw_data    = 6'((i * 7 + c * 11 + 3) % 64);
            hr_addr    = 8'($urandom);
            hr_comp    = 2'($urandom);
            tick();
         end
      end
      // R2: pointer wrapped to 0; write there without loading
      idle(); hw_wr = 1; hw_comp = 0; hw_data = 6'h2a; tick();
      // R2: load 250 alone, then code-3 writes that store nothing
      idle(); hw_addr_ld = 1; hw_addr = 8'd250; tick();
      for (int i = 0; i < 8; i++) begin
         idle(); hw_wr = 1; hw_comp = 2'd3; hw_data = 6'h3f; tick();
      end
      idle(); hw_wr = 1; hw_comp = 2'd2; hw_data = 6'h15; tick();

      // R2 / R10: read back every entry of every table code
      rd_tag = "R2";
      for (int c = 0; c < 4; c++) begin
         for (int i = 0; i < 256; i++) begin
            idle(); hr_comp = 2'(c); hr_addr = 8'(i); tick();
         end
      end
      rd_tag = "R10";

      // R3 / R8: indexed
      for (int i = 0; i < 300; i++) begin idle(); rand_pix(0, 0); tick(); end
      // R4, R5, R6: direct formats with corner words
      for (int m = 1; m < 4; m++) begin
         for (int i = 0; i < 200; i++) begin idle(); rand_pix(m, 0); tick(); end
         foreach (pix_data[k]) begin end
         idle(); pix_valid = 1; pix_mode = 2'(m); pix_data = 24'hff8000; tick();
         idle(); pix_valid = 1; pix_mode = 2'(m); pix_data = 24'h007fff; tick();
         idle(); pix_valid = 1; pix_mode = 2'(m); pix_data = 24'hffffff; tick();
         idle(); pix_valid = 1; pix_mode = 2'(m); pix_data = 24'h000000; tick();
      end
      // R7: doubled in mode 0, then ignored in modes 1..3
      for (int i = 0; i < 300; i++) begin idle(); rand_pix(0, 1); tick(); end
      for (int i = 0; i < 150; i++) begin idle(); rand_pix(1 + i % 3, 1); tick(); end

      // R9: write and lookup colliding on the same entry
      for (int k = 0; k < 24; k++) begin
         logic [7:0] a;
         a = 8'($urandom);
         idle();
         hw_addr_ld = 1; hw_addr = a; hw_wr = 1;
         hw_comp = 2'(k % 3); hw_data = 6'($urandom);
         pix_valid = 1; pix_mode = 0; dbl_mode = k[0];
         pix_data = k[0] ? {8'($urandom), a, 8'($urandom)} : {16'($urandom), a};
         hr_addr = a; hr_comp = 2'(k % 3);
         tick();
         hw_addr_ld = 0; hw_wr = 0;
         tick();
      end

      // Mixed traffic
      for (int i = 0; i < 1500; i++) begin
         idle();
         rand_pix(int'($urandom % 4), 1'($urandom));
         hw_addr_ld = ($urandom % 8) == 0;
         hw_addr    = 8'($urandom);
         hw_wr      = ($urandom % 3) == 0;
         hw_comp    = 2'($urandom);
         hw_data    = 6'($urandom);
         tick();
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R8 watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule